// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Target

This block answers accesses on a bus whose data lines carry the address first and the data after. A bus cycle starts with a one-cycle start strobe while the chip select is active. In that single cycle the target stores three things: the byte address from the low data lines, the transfer size code from the three most significant data lines, and the read/write direction. Every later cycle with chip select active is a data beat. The target turns each beat into one access on its memory-side port, which carries an address, a write enable, byte enables and data. The frame strobe is low during the final beat, and that closes the access.

Byte, word and longword accesses take a single beat. Their byte enables come from the size and the low address bits. A 32-byte burst takes as many beats as 32 bytes need at the bus width. The burst starts at the requested bus word and steps by one bus word per beat, wrapping inside the aligned 32-byte block. The size code 011 is reserved. It sets a sticky error flag, and that access writes nothing. The memory behind the port must return read data combinationally, in the same cycle as the address.

Top module: `mpx_tgt`

## Requirements
- R1: While reset is active and after it, until a start strobe arrives, `mem_en_o`, `mem_we_o`, `bus_oe_o` and `err_o` are low.
- R2: In a cycle with `bus_strt_i` and `bus_sel_i` high, the block stores `bus_d_i[AW-1:0]` as the address, `bus_d_i[DW-1:DW-3]` as the size code and `bus_rnw_i` as the direction. It makes no memory access in that cycle. Values on the data lines in later cycles do not change the stored address.
- R3: After a start strobe, each cycle with `bus_sel_i` high is a beat, and `mem_en_o` is high in it. A beat with `bus_frm_i` low is the final one. After the final beat, `mem_en_o` stays low until the next start strobe, even if `bus_sel_i` stays high.
- R4: The single-beat size codes are 000 (byte), 001 (word) and 010 (longword). For these, `mem_addr_o` is the stored address. `mem_be_o` enables 1, 2 or 4 bytes, starting at the lane given by the low address bits rounded down to the size.
- R5: A size code with the top bit set (1xx) is a burst. Beat k uses the address with bits 4 down to log2(DW/8) equal to the stored field plus k, taken modulo the block. The bits below that field are zero, and the bits above bit 4 are unchanged. All byte enables are high.
- R6: On a write beat (direction low, non-reserved code), `mem_we_o` is high and `mem_wdata_o` equals `bus_d_i` of that cycle.
- R7: On every read beat (direction high), `bus_oe_o` is high and `bus_d_o` equals `mem_rdata_i` of the same cycle. Outside read beats, `bus_oe_o` is low.
- R8: Size code 011 makes `err_o` high from the clock edge that stores it until reset. An access with that code has `mem_we_o` low and `mem_be_o` zero, so memory contents stay unchanged.
- R9: A start strobe in the cycle right after a final beat, with `bus_sel_i` held high throughout, is accepted like any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_strt_i | input | 1 | Start strobe, high for the address phase |
| bus_sel_i | input | 1 | Chip select, active high |
| bus_frm_i | input | 1 | Frame strobe, low in the final beat |
| bus_rnw_i | input | 1 | Direction in the address phase: 1 read, 0 write |
| bus_d_i | input | DW | Data lines from the bus |
| bus_d_o | output | DW | Read data towards the bus |
| bus_oe_o | output | 1 | Drive enable for `bus_d_o` |
| mem_en_o | output | 1 | Memory access in this cycle |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Memory byte address |
| mem_be_o | output | DW/8 | Memory byte enables |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, combinational |
| err_o | output | 1 | Sticky reserved-code flag |

## Verification
The hardest cases to reach are a burst that starts inside its 32-byte block and wraps, and a new start strobe placed straight after a final beat while chip select never drops. A beat counter that runs off or an address that leaves the block shows up only on those paths. The bench drives bursts at chosen mid-block offsets, then runs a fixed-seed random mix with idle gaps of zero to two cycles. In the idle cycles chip select is randomly high or low. A reserved-code write is followed by a read of the same word, which proves at the port that memory did not change.

// File: rtl/mpx_tgt_pkg.sv
package mpx_tgt_pkg;

   typedef enum logic [2:0] {
      K_BYTE  = 3'd0,
      K_WORD  = 3'd1,
      K_LONG  = 3'd2,
      K_RSVD  = 3'd3,
      K_BURST = 3'd4
   } xfer_kind_e;

   // size code from the three top data lines
   function automatic xfer_kind_e kind_of(input logic [2:0] code);
      if (code[2]) return K_BURST;
      case (code[1:0])
         2'd0:    return K_BYTE;
         2'd1:    return K_WORD;
         2'd2:    return K_LONG;
         default: return K_RSVD;
      endcase
   endfunction

   function automatic logic [3:0] unit_bytes(input xfer_kind_e k);
      case (k)
         K_BYTE:  return 4'd1;
         K_WORD:  return 4'd2;
         K_LONG:  return 4'd4;
         default: return 4'd0;
      endcase
   endfunction

endpackage

// File: rtl/mpx_tgt_capture.sv
module mpx_tgt_capture
   import mpx_tgt_pkg::*;
#(
   parameter int DW = 32,
   parameter int AW = 26
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               take_i,
   input  logic [DW-1:0]      d_i,
   input  logic               rnw_i,
   output logic [AW-1:0]      base_o,
   output xfer_kind_e         kind_o,
   output logic               rnw_o,
   output logic               rsvd_seen_o
);
   localparam int CODE_LSB = DW - 3;

   xfer_kind_e kind_in;
   logic       unused_pad;

   assign kind_in    = kind_of(d_i[DW-1:CODE_LSB]);
   assign unused_pad = ^d_i[CODE_LSB-1:AW];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         base_o      <= '0;
         kind_o      <= K_BYTE;
         rnw_o       <= 1'b1;
         rsvd_seen_o <= 1'b0;
      end else if (take_i) begin
         base_o <= d_i[AW-1:0];
         kind_o <= kind_in;
         rnw_o  <= rnw_i;
         if (kind_in == K_RSVD) rsvd_seen_o <= 1'b1;
      end
   end

endmodule

// File: rtl/mpx_tgt_seq.sv
module mpx_tgt_seq #(
   parameter int BW = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          strt_i,
   input  logic          sel_i,
   input  logic          frm_i,
   output logic          act_o,
   output logic          beat_o,
   output logic [BW-1:0] cnt_o
);
   logic          act_q;
   logic [BW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (strt_i && sel_i) begin
         act_q <= 1'b1;
         cnt_q <= '0;
      end else if (act_q && sel_i) begin
         cnt_q <= cnt_q + 1'b1;
         if (!frm_i) act_q <= 1'b0;
      end
   end

   assign act_o  = act_q;
   assign beat_o = act_q & sel_i & ~strt_i;
   assign cnt_o  = cnt_q;

endmodule

// File: rtl/mpx_tgt_lanes.sv
module mpx_tgt_lanes
   import mpx_tgt_pkg::*;
#(
   parameter  int DW  = 32,
   localparam int NB  = DW / 8,
   localparam int LW  = $clog2(NB),
   localparam int NBW = LW + 1
) (
   input  xfer_kind_e     kind_i,
   input  logic [LW-1:0]  lo_i,
   output logic [NB-1:0]  be_o
);
   logic [NBW-1:0] nb;
   logic [LW-1:0]  mask;
   logic [LW-1:0]  start;

   always_comb begin
      nb    = NBW'(unit_bytes(kind_i));
      mask  = LW'(nb - 1'b1);
      start = lo_i & ~mask;
   end

   for (genvar g = 0; g < NB; g++) begin : g_lane
      assign be_o[g] = (kind_i == K_BURST) ||
                       ((nb != '0) && (g >= int'(start)) &&
                        (g < int'(start) + int'(nb)));
   end

endmodule

// File: rtl/mpx_tgt.sv
module mpx_tgt
   import mpx_tgt_pkg::*;
#(
   parameter int DW = 32,
   parameter int AW = 26
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_strt_i,
   input  logic              bus_sel_i,
   input  logic              bus_frm_i,
   input  logic              bus_rnw_i,
   input  logic [DW-1:0]     bus_d_i,
   output logic [DW-1:0]     bus_d_o,
   output logic              bus_oe_o,
   output logic              mem_en_o,
   output logic              mem_we_o,
   output logic [AW-1:0]     mem_addr_o,
   output logic [DW/8-1:0]   mem_be_o,
   output logic [DW-1:0]     mem_wdata_o,
   input  logic [DW-1:0]     mem_rdata_i,
   output logic              err_o
);
   localparam int NB  = DW / 8;
   localparam int LW  = $clog2(NB);
   localparam int BLK = 5;
   localparam int BW  = BLK - LW;

   if (DW != 32 && DW != 64) begin : g_bad_dw
      $error("mpx_tgt: DW must be 32 or 64");
   end
   if (AW <= BLK || AW >= DW - 3) begin : g_bad_aw
      $error("mpx_tgt: AW must lie above the block bits and below the code bits");
   end

   logic [AW-1:0] base_q;
   xfer_kind_e    kind_q;
   logic          rnw_q;
   logic          act;
   logic          beat;
   logic [BW-1:0] cnt_q;

   mpx_tgt_capture #(.DW(DW), .AW(AW)) u_cap (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .take_i      (bus_strt_i & bus_sel_i),
      .d_i         (bus_d_i),
      .rnw_i       (bus_rnw_i),
      .base_o      (base_q),
      .kind_o      (kind_q),
      .rnw_o       (rnw_q),
      .rsvd_seen_o (err_o)
   );

   mpx_tgt_seq #(.BW(BW)) u_seq (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .strt_i (bus_strt_i),
      .sel_i  (bus_sel_i),
      .frm_i  (bus_frm_i),
      .act_o  (act),
      .beat_o (beat),
      .cnt_o  (cnt_q)
   );

   mpx_tgt_lanes #(.DW(DW)) u_lanes (
      .kind_i (kind_q),
      .lo_i   (base_q[LW-1:0]),
      .be_o   (mem_be_o)
   );

   logic unused_act;
   assign unused_act = act;

   // burst beats walk the bus-word field and wrap inside the 32-byte block
   always_comb begin
      if (kind_q == K_BURST)
         mem_addr_o = {base_q[AW-1:BLK], base_q[BLK-1:LW] + cnt_q, {LW{1'b0}}};
      else
         mem_addr_o = base_q;
   end

   assign mem_en_o    = beat;
   assign mem_we_o    = beat & ~rnw_q & (kind_q != K_RSVD);
   assign mem_wdata_o = bus_d_i;
   assign bus_oe_o    = beat & rnw_q;
   assign bus_d_o     = mem_rdata_i;

endmodule

// File: rtl/mpx_tgt_chk.sv
module mpx_tgt_chk
   import mpx_tgt_pkg::*;
#(
   parameter int DW = 32,
   parameter int AW = 26
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            bus_strt_i,
   input logic            bus_frm_i,
   input logic            bus_oe_o,
   input logic            mem_en_o,
   input logic            mem_we_o,
   input logic [AW-1:0]   mem_addr_o,
   input logic [DW/8-1:0] mem_be_o,
   input logic            err_o,
   input xfer_kind_e      kind_i
);

   p_quiet_addr_phase_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_strt_i |-> !mem_en_o);

   p_stop_after_last_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_en_o && !bus_frm_i) |=> !mem_en_o);

   p_block_kept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_en_o && bus_frm_i) |=>
         (!mem_en_o || mem_addr_o[AW-1:5] == $past(mem_addr_o[AW-1:5])));

   p_burst_lanes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_en_o && kind_i == K_BURST) |-> (&mem_be_o));

   p_single_width_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mem_en_o && kind_i != K_BURST) |-> ($countones(mem_be_o) <= 4));

   p_oe_on_reads_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_oe_o |-> (mem_en_o && !mem_we_o));

   p_write_has_lanes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_we_o |-> (mem_be_o != '0));

   p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |=> err_o);

endmodule

bind mpx_tgt mpx_tgt_chk #(.DW(DW), .AW(AW)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .bus_strt_i (bus_strt_i),
   .bus_frm_i  (bus_frm_i),
   .bus_oe_o   (bus_oe_o),
   .mem_en_o   (mem_en_o),
   .mem_we_o   (mem_we_o),
   .mem_addr_o (mem_addr_o),
   .mem_be_o   (mem_be_o),
   .err_o      (err_o),
   .kind_i     (kind_q)
);

// File: tb/mpx_tgt_tb.sv
module mpx_tgt_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        strt, sel, frm, rnw;
   logic [31:0] d_in, d_out, wdata, rdata;
   logic        oe, en, we, err;
   logic [25:0] addr;
   logic [3:0]  be;

   logic [31:0] mdl [64];
   int          n_cmp = 0;
   int          n_bad = 0;
   bit          exp_err = 1'b0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   assign rdata = mdl[addr[7:2]];

   mpx_tgt #(.DW(32), .AW(26)) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bus_strt_i  (strt),
      .bus_sel_i   (sel),
      .bus_frm_i   (frm),
      .bus_rnw_i   (rnw),
      .bus_d_i     (d_in),
      .bus_d_o     (d_out),
      .bus_oe_o    (oe),
      .mem_en_o    (en),
      .mem_we_o    (we),
      .mem_addr_o  (addr),
      .mem_be_o    (be),
      .mem_wdata_o (wdata),
      .mem_rdata_i (rdata),
      .err_o       (err)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
      end
   endtask

   function automatic logic [3:0] exp_be(input logic [2:0] c, input logic [25:0] a);
      if (c[2]) return 4'hF;
      case (c[1:0])
         2'd0:    return 4'b0001 << a[1:0];
         2'd1:    return a[1] ? 4'b1100 : 4'b0011;
         2'd2:    return 4'hF;
         default: return 4'h0;
      endcase
   endfunction

   function automatic logic [25:0] exp_addr(input logic [2:0] c, input logic [25:0] a, input int k);
      logic [2:0] f;
      if (!c[2]) return a;
      f = a[4:2] + 3'(k);
      return {a[25:5], f, 2'b00};
   endfunction

   task automatic idle(input logic sel_v);
      @(negedge clk);
      strt = 1'b0; sel = sel_v; frm = 1'b1; d_in = $urandom;
      #1;
      chk("R3 idle no access", {63'd0, en}, 64'd0);
      chk("R7 idle no drive", {63'd0, oe}, 64'd0);
      chk("R8 flag", {63'd0, err}, {63'd0, exp_err});
   endtask

   task automatic xfer(input logic [2:0] code, input logic [25:0] a, input logic rnw_v,
                       input bit b2b, input int gap);
      int          n;
      logic [31:0] wd;
      logic [25:0] ea;
      logic [3:0]  eb;
      bit          wr;
      string       tag;
      tag = code[2] ? "R5" : "R4";
      @(negedge clk);
      strt = 1'b1; sel = 1'b1; frm = 1'b1; rnw = rnw_v;
      d_in = {code, 3'($urandom), a};
      #1;
      chk("R2 no access in address phase", {63'd0, en}, 64'd0);
      if (code == 3'b011) exp_err = 1'b1;
      n = code[2] ? 8 : 1;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         wd = $urandom;
         strt = 1'b0; sel = 1'b1; frm = (k != n - 1); d_in = wd;
         rnw = $urandom;
         #1;
         ea = exp_addr(code, a, k);
         eb = (code == 3'b011) ? 4'h0 : exp_be(code, a);
         wr = !rnw_v && code != 3'b011;
         if (b2b && k == 0) chk("R9 back-to-back accepted", {37'd0, en, addr}, {37'd0, 1'b1, ea});
         chk("R3 beat enable", {63'd0, en}, 64'd1);
         chk({tag, " address"}, {38'd0, addr}, {38'd0, ea});
         chk({tag, " byte enables"}, {60'd0, be}, {60'd0, eb});
         chk(code == 3'b011 ? "R8 write blocked" : "R6 write strobe", {63'd0, we}, {63'd0, wr});
         if (wr) chk("R6 write data", {32'd0, wdata}, {32'd0, wd});
         chk("R7 drive enable", {63'd0, oe}, {63'd0, rnw_v});
         if (rnw_v) chk("R7 read data", {32'd0, d_out}, {32'd0, mdl[ea[7:2]]});
         chk("R8 flag", {63'd0, err}, {63'd0, exp_err});
         if (wr)
            for (int b = 0; b < 4; b++)
               if (eb[b]) mdl[ea[7:2]][b*8 +: 8] = wd[b*8 +: 8];
      end
      for (int g = 0; g < gap; g++) idle($urandom % 2 == 0);
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 64; i++) mdl[i] = (i * 32'h0101_0101) ^ 32'hA5A5_0000;
      rst_n = 1'b0; strt = 1'b0; sel = 1'b0; frm = 1'b1; rnw = 1'b1; d_in = '0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset access", {62'd0, en, we}, 64'd0);
      chk("R1 reset drive/flag", {62'd0, oe, err}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(1'b1);
      // directed single beats
      xfer(3'b000, 26'h000_0013, 1'b0, 1'b0, 1);
      xfer(3'b001, 26'h000_0042, 1'b0, 1'b0, 1);
      xfer(3'b010, 26'h000_0047, 1'b1, 1'b0, 1);
      xfer(3'b000, 26'h000_0010, 1'b1, 1'b0, 1);
      // wrapping bursts from mid-block offsets
      xfer(3'b100, 26'h3AB_CDB4, 1'b0, 1'b0, 1);
      xfer(3'b111, 26'h000_00A8, 1'b1, 1'b0, 0);
      // back-to-back with select held
      xfer(3'b001, 26'h000_0106, 1'b0, 1'b1, 0);
      xfer(3'b010, 26'h000_0104, 1'b1, 1'b1, 1);
      // reserved code: flag and no write, then read the same word back
      xfer(3'b011, 26'h000_0020, 1'b0, 1'b0, 1);
      xfer(3'b010, 26'h000_0020, 1'b1, 1'b0, 1);
      // random mix
      begin
         bit last_b2b = 1'b0;
         for (int t = 0; t < 400; t++) begin
            int gp;
            gp = $urandom % 3;
            xfer(3'($urandom), 26'($urandom), 1'($urandom), last_b2b, gp);
            last_b2b = (gp == 0);
         end
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule